// File: doc/BRIEF.md
# Flash command timing sequencer

This block sits between a bus-side register interface and a nonvolatile memory array. It turns the fast bus clock into a slow timing tick through a divider that software programs once after reset. It then runs byte-program, burst byte-program, page-erase and mass-erase commands, each for a fixed whole number of tick periods. While a command runs it holds a program or erase enable toward the array, together with the target address and data. Status outputs report busy, completion and access errors.

Software writes the divider before anything else, then issues commands through a one-cycle strobe with an opcode, address and data. In burst mode a second byte may be handed over while the first one is still being programmed. The second byte then follows without the start overhead and without dropping the program enable. Anything issued at the wrong moment is refused and raises the access-error flag, which stays set until software clears it.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command issued before the divider has been written is not started (busy stays 0) and sets accErr the cycle after it is issued.
- R2: Only the first accepted divider write after reset takes effect; later writes leave the tick period unchanged.
- R3: A divider write while accErr is 1 is ignored, so commands are still refused afterwards.
- R4: cfgWrData bits [5:0] give the divisor d and bit 6 selects a prescale of 8. One tick period is P = (d+1) bus clocks, or 8*(d+1) clocks with the prescale, counted from the accepting edge.
- R5: Opcode 0 (byte program) holds busy and arrProgEn for 9*P cycles, with arrAddr and arrData equal to the issued address and data. arrEraseEn stays 0.
- R6: Opcode 1 (burst) issued again while a burst byte runs is chained. The chained byte adds 4*P cycles with arrProgEn held, and arrAddr switches to the second address.
- R7: A burst byte with nothing chained ends after 9*P cycles and drops busy and arrProgEn.
- R8: Opcode 2 (page erase) holds arrEraseEn for 4000*P cycles, with arrAddr equal to the issued address with its low 9 bits cleared.
- R9: Opcode 3 (mass erase) holds arrEraseEn and arrMass for 20000*P cycles.
- R10: A command issued while busy that cannot be chained sets accErr. It leaves the running operation's length, enables and address untouched.
- R11: Writing 1 through statWrAccErr with statWrEn clears accErr. Writing 0 leaves it set.
- R12: done is 0 after reset, becomes 1 when an operation finishes, and returns to 0 when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Divider register write strobe |
| cfgWrData | input | DIV_W+1 | Divisor in [DIV_W-1:0], prescale-by-8 select in [DIV_W] |
| statWrEn | input | 1 | Status register write strobe |
| statWrAccErr | input | 1 | Write 1 to clear the access-error flag |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 2 | 0 byte program, 1 burst program, 2 page erase, 3 mass erase |
| cmdAddr | input | ADDR_W | Command address |
| cmdData | input | DATA_W | Byte to program |
| arrProgEn | output | 1 | Program enable to the array |
| arrEraseEn | output | 1 | Erase enable to the array |
| arrMass | output | 1 | Whole-array erase select |
| arrAddr | output | ADDR_W | Target address (page-aligned for page erase, zero for mass erase) |
| arrData | output | DATA_W | Byte being programmed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished |
| accErr | output | 1 | Access-error flag |

## Verification
A wrong period counter or tick generator shows up as a busy pulse of the wrong length. The bench measures that length to the exact cycle, so an off-by-one is caught by the first command that ends. A corrupted pending slot or divider lock is visible at once through arrAddr when the chain hand-off happens, or through accErr and busy on the next command. The sweeps over divisor and prescale values therefore expose counter faults within one operation.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_BURST = 2'd1,
    OP_PAGE  = 2'd2,
    OP_MASS  = 2'd3
  } fcsOp_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;  // latch a new command and restart timing
    logic queue;  // park a burst byte in the pending slot
    logic chain;  // move the pending byte into the active slot
  } fcsStrobe_t;

endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 9,
  parameter int BYTE_CYC  = 9,
  parameter int BURST_CYC = 4,
  parameter int PAGE_CYC  = 4000,
  parameter int MASS_CYC  = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DIV_W:0]    cfgWrData,
  input  logic              accErr,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  fcsStrobe_t        strobe,
  output logic              divReady,
  output logic              lastTick,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] curData
);

  localparam int CNT_W = $clog2(MASS_CYC + 1);
  localparam int PRE_W = 3;
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  logic [DIV_W-1:0]  divVal;
  logic              preSel;
  logic [PRE_W-1:0]  preCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              preWrap;
  logic              tick;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  // one-shot divider register, locked while an access error is flagged
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal   <= '0;
      preSel   <= 1'b0;
      divReady <= 1'b0;
    end else if (cfgWrEn && !divReady && !accErr) begin
      divVal   <= cfgWrData[DIV_W-1:0];
      preSel   <= cfgWrData[DIV_W];
      divReady <= 1'b1;
    end
  end

  assign preWrap = !preSel || (preCnt == {PRE_W{1'b1}});
  assign tick    = divReady && preWrap && (divCnt == divVal);

  // tick generator, realigned on every command start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobe.start) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (divReady) begin
      preCnt <= preCnt + 1'b1;
      if (preWrap) divCnt <= (divCnt == divVal) ? '0 : divCnt + 1'b1;
    end
  end

  function automatic logic [CNT_W-1:0] opLength(input logic [1:0] op);
    case (fcsOp_t'(op))
      OP_PAGE: opLength = CNT_W'(PAGE_CYC);
      OP_MASS: opLength = CNT_W'(MASS_CYC);
      default: opLength = CNT_W'(BYTE_CYC);
    endcase
  endfunction

  // period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      remain <= '0;
    else if (strobe.start)          remain <= opLength(cmdOp);
    else if (strobe.chain)          remain <= CNT_W'(BURST_CYC);
    else if (tick && remain != '0)  remain <= remain - 1'b1;
  end

  assign lastTick = tick && (remain == CNT_W'(1));

  // active and pending address/data slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curData  <= '0;
      pendAddr <= '0;
      pendData <= '0;
    end else begin
      if (strobe.start) begin
        case (fcsOp_t'(cmdOp))
          OP_PAGE: curAddr <= cmdAddr & PAGE_MASK;
          OP_MASS: curAddr <= '0;
          default: curAddr <= cmdAddr;
        endcase
        curData <= cmdData;
      end else if (strobe.chain) begin
        curAddr <= pendAddr;
        curData <= pendData;
      end
      if (strobe.queue) begin
        pendAddr <= cmdAddr;
        pendData <= cmdData;
      end
    end
  end

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       divReady,
  input  logic       lastTick,
  input  logic       errClr,
  output fcsStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       accErr,
  output logic       progEn,
  output logic       eraseEn,
  output logic       massEn
);

  fcsOp_t opIn;
  fcsOp_t curOp;
  logic   running;
  logic   pendValid;
  logic   canStart;
  logic   canQueue;
  logic   reject;
  logic   finish;

  always_comb begin
    opIn     = fcsOp_t'(cmdOp);
    canStart = divReady && (!running || (lastTick && !pendValid));
    canQueue = running && !lastTick && (curOp == OP_BURST) &&
               !pendValid && (opIn == OP_BURST);
    strobe.start = cmdValid && canStart;
    strobe.queue = cmdValid && canQueue;
    strobe.chain = running && lastTick && pendValid;
    reject       = cmdValid && !canStart && !canQueue;
    finish       = running && lastTick && !pendValid && !strobe.start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      curOp     <= OP_BYTE;
      pendValid <= 1'b0;
      done      <= 1'b0;
      accErr    <= 1'b0;
    end else begin
      if (strobe.start) begin
        running <= 1'b1;
        curOp   <= opIn;
        done    <= 1'b0;
      end else if (finish) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
      if (strobe.chain)      pendValid <= 1'b0;
      else if (strobe.queue) pendValid <= 1'b1;
      if (reject)            accErr <= 1'b1;
      else if (errClr)       accErr <= 1'b0;
    end
  end

  always_comb begin
    busy    = running;
    progEn  = running && (curOp == OP_BYTE || curOp == OP_BURST);
    eraseEn = running && (curOp == OP_PAGE || curOp == OP_MASS);
    massEn  = running && (curOp == OP_MASS);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 9,
  parameter int BYTE_CYC  = 9,
  parameter int BURST_CYC = 4,
  parameter int PAGE_CYC  = 4000,
  parameter int MASS_CYC  = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DIV_W:0]    cfgWrData,
  input  logic              statWrEn,
  input  logic              statWrAccErr,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              arrProgEn,
  output logic              arrEraseEn,
  output logic              arrMass,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic              busy,
  output logic              done,
  output logic              accErr
);

  fcsStrobe_t strobe;
  logic       divReady;
  logic       lastTick;
  logic       errClr;

  assign errClr = statWrEn && statWrAccErr;

  fcs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .divReady (divReady),
    .lastTick (lastTick),
    .errClr   (errClr),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .accErr   (accErr),
    .progEn   (arrProgEn),
    .eraseEn  (arrEraseEn),
    .massEn   (arrMass)
  );

  fcs_datapath #(
    .DIV_W     (DIV_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS),
    .BYTE_CYC  (BYTE_CYC),
    .BURST_CYC (BURST_CYC),
    .PAGE_CYC  (PAGE_CYC),
    .MASS_CYC  (MASS_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .accErr    (accErr),
    .cmdOp     (cmdOp),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .strobe    (strobe),
    .divReady  (divReady),
    .lastTick  (lastTick),
    .curAddr   (arrAddr),
    .curData   (arrData)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              divReady,
  input logic              lastTick,
  input logic              busy,
  input logic              done,
  input logic              accErr,
  input logic              arrProgEn,
  input logic              arrEraseEn,
  input logic              arrMass,
  input logic [ADDR_W-1:0] arrAddr
);

  p_no_dual_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(arrProgEn && arrEraseEn));

  p_busy_has_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy == (arrProgEn || arrEraseEn));

  p_mass_is_erase_r9: assert property (@(posedge clk) disable iff (!rstN)
    arrMass |-> arrEraseEn);

  p_page_aligned_r8: assert property (@(posedge clk) disable iff (!rstN)
    (arrEraseEn && !arrMass) |-> (arrAddr[PAGE_BITS-1:0] == '0));

  p_reject_undivided_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !divReady) |=> (accErr && !busy));

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && cmdOp != 2'd1 && !lastTick) |=>
      (accErr && busy && $stable(arrAddr) && $stable(arrProgEn)));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastTick) |=> $stable(arrAddr));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind flash_cmd_seq fcs_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .divReady   (divReady),
  .lastTick   (lastTick),
  .busy       (busy),
  .done       (done),
  .accErr     (accErr),
  .arrProgEn  (arrProgEn),
  .arrEraseEn (arrEraseEn),
  .arrMass    (arrMass),
  .arrAddr    (arrAddr)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [6:0]  cfgWrData;
  logic        statWrEn;
  logic        statWrAccErr;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [15:0] cmdAddr;
  logic [7:0]  cmdData;
  logic        arrProgEn, arrEraseEn, arrMass;
  logic [15:0] arrAddr;
  logic [7:0]  arrData;
  logic        busy, done, accErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .statWrEn(statWrEn), .statWrAccErr(statWrAccErr),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .arrProgEn(arrProgEn), .arrEraseEn(arrEraseEn), .arrMass(arrMass),
    .arrAddr(arrAddr), .arrData(arrData),
    .busy(busy), .done(done), .accErr(accErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWrEn = 0; cfgWrData = 0; statWrEn = 0; statWrAccErr = 0;
    cmdValid = 0; cmdOp = 0; cmdAddr = 0; cmdData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [6:0] v);
    cfgWrEn = 1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic statWrite(input logic b);
    statWrEn = 1; statWrAccErr = b;
    @(negedge clk);
    statWrEn = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    cmdValid = 1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 0;
  endtask

  // counts busy cycles from the current negedge until busy falls
  task automatic runOp(output int cyc, output logic [15:0] lastA,
                       output logic sawProg, output logic sawErase);
    cyc = 0; sawProg = 0; sawErase = 0; lastA = arrAddr;
    while (busy && cyc < 40000) begin
      cyc++;
      lastA = arrAddr;
      if (arrProgEn) sawProg = 1;
      if (arrEraseEn) sawErase = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] la;
    logic sp, se;

    doReset();
    // reset state (R12, R5)
    check(!busy && !done && !accErr, "R12 reset status", {busy, done, accErr}, 0);
    check(!arrProgEn && !arrEraseEn, "R5 reset enables", {arrProgEn, arrEraseEn}, 0);

    // R1: command before divider is written
    issue(2'd0, 16'h0010, 8'h11);
    check(!busy, "R1 busy", busy, 0);
    check(accErr, "R1 accErr", accErr, 1);

    // R3: divider write ignored while error set
    cfgWrite(7'd0);
    // R11: writing 0 does not clear, writing 1 does
    statWrite(1'b0);
    check(accErr, "R11 write0 keeps", accErr, 1);
    statWrite(1'b1);
    check(!accErr, "R11 write1 clears", accErr, 0);
    issue(2'd0, 16'h0010, 8'h11);
    check(!busy && accErr, "R3 divider stayed unwritten", {busy, accErr}, 1);
    statWrite(1'b1);

    // now the divider takes effect (d=0, P=1)
    cfgWrite(7'd0);
    issue(2'd0, 16'h1234, 8'hA5);
    check(arrProgEn && !arrEraseEn, "R5 prog enable", {arrProgEn, arrEraseEn}, 2);
    check(arrAddr == 16'h1234, "R5 addr", arrAddr, 16'h1234);
    check(arrData == 8'hA5, "R5 data", arrData, 8'hA5);
    runOp(n, la, sp, se);
    check(n == 9, "R5 byte length", n, 9);
    check(done, "R12 done set", done, 1);
    repeat (3) @(negedge clk);
    check(done, "R12 done held", done, 1);

    // R2: second divider write has no effect
    cfgWrite(7'd5);
    issue(2'd0, 16'h0001, 8'h01);
    check(!done, "R12 done cleared on accept", done, 0);
    runOp(n, la, sp, se);
    check(n == 9, "R2 divider locked", n, 9);

    // R7: lone burst byte
    issue(2'd1, 16'h0200, 8'h22);
    runOp(n, la, sp, se);
    check(n == 9 && sp, "R7 lone burst", n, 9);
    check(!arrProgEn, "R7 prog dropped", arrProgEn, 0);

    // R6: chained burst
    issue(2'd1, 16'h0300, 8'h33);
    check(arrAddr == 16'h0300, "R6 first addr", arrAddr, 16'h0300);
    issue(2'd1, 16'h0301, 8'h34);
    runOp(n, la, sp, se);
    check(n + 1 == 13, "R6 chain length", n + 1, 13);
    check(la == 16'h0301, "R6 second addr", la, 16'h0301);
    check(!accErr, "R6 no error on chain", accErr, 0);

    // R10: command while busy is refused
    issue(2'd0, 16'h0400, 8'h44);
    issue(2'd2, 16'h0800, 8'h00);
    check(accErr, "R10 accErr", accErr, 1);
    check(arrAddr == 16'h0400 && arrProgEn, "R10 addr kept", arrAddr, 16'h0400);
    runOp(n, la, sp, se);
    check(n + 1 == 9 && !se, "R10 length kept", n + 1, 9);
    statWrite(1'b1);

    // R8: page erase
    issue(2'd2, 16'h3FFF, 8'h00);
    check(arrEraseEn && !arrMass && !arrProgEn, "R8 erase enable", {arrEraseEn, arrMass}, 2);
    check(arrAddr == 16'h3E00, "R8 page aligned", arrAddr, 16'h3E00);
    runOp(n, la, sp, se);
    check(n == 4000, "R8 page length", n, 4000);

    // R9: mass erase
    issue(2'd3, 16'h5555, 8'h00);
    check(arrEraseEn && arrMass, "R9 mass enable", {arrEraseEn, arrMass}, 3);
    runOp(n, la, sp, se);
    check(n == 20000, "R9 mass length", n, 20000);

    // R4: divisor and prescale sweep
    for (int pre = 0; pre < 2; pre++) begin
      for (int k = 0; k < 5; k++) begin
        int d;
        int p;
        d = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 7 : 63;
        p = (d + 1) * (pre == 1 ? 8 : 1);
        doReset();
        cfgWrite({pre[0], d[5:0]});
        issue(2'd0, 16'h0042, 8'h42);
        runOp(n, la, sp, se);
        check(n == 9 * p, "R4 byte period", n, 9 * p);
      end
    end

    // R6 with slower tick: chained byte at d=2
    doReset();
    cfgWrite(7'd2);
    issue(2'd1, 16'h0500, 8'h50);
    issue(2'd1, 16'h0501, 8'h51);
    runOp(n, la, sp, se);
    check(n + 1 == 13 * 3, "R6 chain length d=2", n + 1, 39);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule